// File: doc/BRIEF.md
# Five-Port Mesh Router with Two Service Classes

This router sits at one node of a two-dimensional mesh and moves wormhole packets between its four compass neighbours and the local cluster. A flit is 34 bits wide. The top two bits mark the start and the end of a packet, and the lower 32 bits are payload. The first flit of a packet names the destination node as an absolute (Y,X) pair. The router compares that pair with its own coordinate, which is set by parameters. A packet travels along X first, then along Y, and it leaves on the local port once both match.

Every link carries two traffic classes: guaranteed service (class 0) and best effort (class 1). Each class has its own 7-entry FIFO at every input. A sender drives a flit together with one class write strobe. The flit moves on a clock edge where that strobe and the receiver's matching write-ok are both high. An output that is idle takes the next packet from a waiting guaranteed-service head if one exists, and otherwise from a best-effort head. Inputs of the same class share an output by round-robin. Once an output has granted a packet, it belongs to that packet until the end-of-packet flit has passed.

Top module: `xy_mesh_router`

## Requirements
- R1: Flit bit 33 marks start of packet and bit 32 marks end of packet. On a start flit, bits [7:4] hold destination Y and bits [3:0] hold destination X. Flits leave the router unaltered and in the same class they arrived in.
- R2: Port indices are 0 local, 1 north, 2 south, 3 east and 4 west. A packet whose destination X is above the home X goes to port 3, and one whose X is below goes to port 4. If X matches, a higher Y goes to port 1 and a lower Y goes to port 2. If both match, the packet goes to port 0.
- R3: For each port and class, write-ok is low exactly while that FIFO holds 7 flits. A write presented while write-ok is low is discarded.
- R4: A flit leaves an output only on an edge where that class's write and the downstream write-ok are both high. While it waits, the write strobe and the flit hold steady.
- R5: Once an output has sent a start flit, no flit of any other packet appears on it until the matching end flit has gone.
- R6: When an idle output has both classes waiting, the class-0 packet goes first. A class-1 packet already under way is never cut into by class 0.
- R7: Inputs of the same class that compete for one output are served round-robin. An input that has just been served ranks last.
- R8: Flits from one input FIFO leave in the order they were written.
- R9: Without contention or backpressure, the flits of one packet leave on consecutive cycles.
- R10: An output asserts at most one class write strobe per cycle.
- R11: During and right after reset, every output write strobe is low and every input write-ok is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Router clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_flit | input | 5x34 | Incoming flit per port |
| rx_wr | input | 5x2 | Incoming write strobe per port and class |
| rx_wok | output | 5x2 | Space available per input port and class |
| tx_flit | output | 5x34 | Outgoing flit per port |
| tx_wr | output | 5x2 | Outgoing write strobe per port and class |
| tx_wok | input | 5x2 | Downstream space per output port and class |

## Verification
A corrupted FIFO pointer or count shows up at the next transfer from that input. It appears as a duplicated, lost or reordered flit, or as write-ok failing to drop after the seventh stored flit. A stale output lock or a wrong owner index shows within one cycle of the next head flit. Symptoms are a start flit on the wrong port, flits of two packets mixed on one link, or both class strobes high together. A round-robin pointer that fails to advance only shows when packets contend, so the bench queues a second packet behind the first and watches which source is served last.

// File: rtl/xy_mesh_router.sv
`timescale 1ns/1ps
module xy_mesh_router #(
  parameter int PW     = 32,
  parameter int DEPTH  = 7,
  parameter int CW     = 4,
  parameter int HOME_X = 2,
  parameter int HOME_Y = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [4:0][PW+1:0]         rx_flit,
  input  logic [4:0][1:0]            rx_wr,
  output logic [4:0][1:0]            rx_wok,
  output logic [4:0][PW+1:0]         tx_flit,
  output logic [4:0][1:0]            tx_wr,
  input  logic [4:0][1:0]            tx_wok
);
  localparam int FW   = PW + 2;
  localparam int NP   = 5;
  localparam int NC   = 2;
  localparam int SOP  = FW - 1;
  localparam int EOP  = FW - 2;
  localparam int AW   = $clog2(DEPTH);
  localparam int KW   = $clog2(DEPTH + 1);
  localparam int IW   = 3;
  localparam logic [IW-1:0] P_LOC = 3'd0, P_N = 3'd1, P_S = 3'd2, P_E = 3'd3, P_W = 3'd4;
  localparam logic [CW-1:0] HX = CW'(HOME_X);
  localparam logic [CW-1:0] HY = CW'(HOME_Y);

  logic [FW-1:0]                 head [NP][NC];
  logic [NP-1:0][NC-1:0]         nonempty, pop;
  logic [NP-1:0][NC-1:0][NP-1:0] req;
  logic [NP-1:0][IW-1:0]         own_v;
  logic [NP-1:0]                 cls_v, xfer;

  function automatic logic [IW-1:0] xroute(input logic [FW-1:0] f);
    logic [CW-1:0] dx, dy;
    dx = f[CW-1:0];
    dy = f[2*CW-1:CW];
    if (dx > HX)      return P_E;
    else if (dx < HX) return P_W;
    else if (dy > HY) return P_N;
    else if (dy < HY) return P_S;
    else              return P_LOC;
  endfunction

  function automatic logic [IW:0] rr_pick(input logic [NP-1:0] r, input logic [IW-1:0] last);
    logic [IW:0] res;
    int j;
    res = '0;
    for (int k = 1; k <= NP; k++) begin
      j = int'(last) + k;
      if (j >= NP) j = j - NP;
      if (!res[IW] && r[j]) res = {1'b1, IW'(j)};
    end
    return res;
  endfunction

  for (genvar i = 0; i < NP; i++) begin : g_in
    for (genvar c = 0; c < NC; c++) begin : g_vc
      logic [FW-1:0] mem [DEPTH];
      logic [AW-1:0] rp, wp;
      logic [KW-1:0] cnt;
      logic          push;

      assign rx_wok[i][c]   = (cnt != KW'(DEPTH));
      assign push           = rx_wr[i][c] && rx_wok[i][c];
      assign nonempty[i][c] = (cnt != '0);
      assign head[i][c]     = mem[rp];

      always_ff @(posedge clk)
        if (push) mem[wp] <= rx_flit[i];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rp  <= '0;
          wp  <= '0;
          cnt <= '0;
        end else begin
          if (push)      wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
          if (pop[i][c]) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
          cnt <= cnt + KW'(push) - KW'(pop[i][c]);
        end
      end
    end
  end

  always_comb begin
    req = '0;
    for (int o = 0; o < NP; o++)
      for (int c = 0; c < NC; c++)
        for (int i = 0; i < NP; i++)
          req[o][c][i] = nonempty[i][c] && head[i][c][SOP] && (xroute(head[i][c]) == IW'(o));
  end

  always_comb begin
    pop = '0;
    for (int o = 0; o < NP; o++)
      if (xfer[o]) pop[own_v[o]][cls_v[o]] = 1'b1;
  end

  for (genvar o = 0; o < NP; o++) begin : g_out
    logic          busy_q, cls_q;
    logic [IW-1:0] own_q, last_gs_q, last_be_q;
    logic [IW:0]   gs_sel, be_sel;

    assign gs_sel     = rr_pick(req[o][0], last_gs_q);
    assign be_sel     = rr_pick(req[o][1], last_be_q);
    assign tx_flit[o] = head[own_q][cls_q];
    assign tx_wr[o]   = busy_q ? (NC'(nonempty[own_q][cls_q]) << cls_q) : '0;
    assign xfer[o]    = |(tx_wr[o] & tx_wok[o]);
    assign own_v[o]   = own_q;
    assign cls_v[o]   = cls_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy_q    <= 1'b0;
        cls_q     <= 1'b0;
        own_q     <= '0;
        last_gs_q <= '0;
        last_be_q <= '0;
      end else if (!busy_q) begin
        if (gs_sel[IW]) begin
          busy_q    <= 1'b1;
          cls_q     <= 1'b0;
          own_q     <= gs_sel[IW-1:0];
          last_gs_q <= gs_sel[IW-1:0];
        end else if (be_sel[IW]) begin
          busy_q    <= 1'b1;
          cls_q     <= 1'b1;
          own_q     <= be_sel[IW-1:0];
          last_be_q <= be_sel[IW-1:0];
        end
      end else if (xfer[o] && tx_flit[o][EOP]) begin
        busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/xy_mesh_router_chk.sv
`timescale 1ns/1ps
module xy_mesh_router_chk #(
  parameter int PW     = 32,
  parameter int CW     = 4,
  parameter int HOME_X = 2,
  parameter int HOME_Y = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [4:0][1:0]     rx_wok,
  input logic [4:0][PW+1:0]  tx_flit,
  input logic [4:0][1:0]     tx_wr,
  input logic [4:0][1:0]     tx_wok
);
  localparam int FW  = PW + 2;
  localparam int SOP = FW - 1;
  localparam int EOP = FW - 2;

  function automatic int exp_port(input logic [FW-1:0] f);
    int x, y;
    x = int'(f[CW-1:0]);
    y = int'(f[2*CW-1:CW]);
    if (x != HOME_X) return (x > HOME_X) ? 3 : 4;
    if (y != HOME_Y) return (y > HOME_Y) ? 1 : 2;
    return 0;
  endfunction

  logic [1:0] moved;
  always_comb begin
    moved = '0;
    for (int o = 0; o < 5; o++) moved = moved | (tx_wr[o] & tx_wok[o]);
  end

  for (genvar o = 0; o < 5; o++) begin : g_o
    p_one_class_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tx_wr[o]));
    for (genvar c = 0; c < 2; c++) begin : g_c
      p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr[o][c] && !tx_wok[o][c] |=> tx_wr[o][c] && $stable(tx_flit[o]));
      p_no_cut_in_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr[o][c] && tx_wok[o][c] && !tx_flit[o][EOP] |=> !tx_wr[o][1-c]);
      p_route_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr[o][c] && tx_flit[o][SOP] |-> exp_port(tx_flit[o]) == o);
    end
  end

  for (genvar i = 0; i < 5; i++) begin : g_i
    for (genvar c = 0; c < 2; c++) begin : g_c
      p_full_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_wok[i][c]) |-> $past(moved[c]));
    end
  end
endmodule

bind xy_mesh_router xy_mesh_router_chk #(
  .PW(PW), .CW(CW), .HOME_X(HOME_X), .HOME_Y(HOME_Y)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_wok(rx_wok),
  .tx_flit(tx_flit), .tx_wr(tx_wr), .tx_wok(tx_wok)
);

// File: tb/xy_mesh_router_tb.sv
`timescale 1ns/1ps
module xy_mesh_router_tb_top;
  localparam int FW = 34;
  localparam int GS = 0, BE = 1;
  localparam int PL = 0, PN = 1, PS = 2, PE = 3, PWST = 4;

  typedef struct packed {
    logic [2:0]    port;
    logic          cls;
    logic [31:0]   cyc;
    logic [FW-1:0] flit;
  } ev_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0][FW-1:0] rx_flit, tx_flit;
  logic [4:0][1:0]    rx_wr, rx_wok, tx_wr, tx_wok;
  int n_chk = 0, n_fail = 0;
  logic [31:0] cyc = 0;
  ev_t evq[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  xy_mesh_router dut_i (
    .clk(clk), .rst_n(rst_n), .rx_flit(rx_flit), .rx_wr(rx_wr), .rx_wok(rx_wok),
    .tx_flit(tx_flit), .tx_wr(tx_wr), .tx_wok(tx_wok)
  );

  always @(negedge clk)
    if (rst_n)
      for (int o = 0; o < 5; o++)
        for (int c = 0; c < 2; c++)
          if (tx_wr[o][c] && tx_wok[o][c])
            evq.push_back('{port: 3'(o), cls: 1'(c), cyc: cyc, flit: tx_flit[o]});

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] mk(bit s, bit e, logic [7:0] tag, int idx, logic [3:0] y, logic [3:0] x);
    return {s, e, tag, 16'(idx), y, x};
  endfunction

  task automatic send_flit(int p, int c, logic [FW-1:0] f);
    rx_flit[p] = f;
    rx_wr[p][c] = 1'b1;
    while (!rx_wok[p][c]) @(negedge clk);
    @(negedge clk);
    rx_wr[p][c] = 1'b0;
  endtask

  task automatic send_pkt(int p, int c, logic [3:0] y, logic [3:0] x, logic [7:0] tag, int len);
    for (int k = 0; k < len; k++)
      send_flit(p, c, mk(k == 0, k == len - 1, tag, k, y, x));
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R11", "tx_wr after reset", tx_wr, 0);
    chk("R11", "rx_wok after reset", rx_wok, 10'h3ff);
  endtask

  task automatic route_case(string nm, int src, int c, logic [3:0] y, logic [3:0] x, int exp_p);
    evq.delete();
    send_pkt(src, c, y, x, 8'hA5, 1);
    idle(8);
    chk("R2", {nm, " count"}, evq.size(), 1);
    if (evq.size() == 1) begin
      chk("R2", {nm, " port"}, evq[0].port, exp_p);
      chk("R1", {nm, " class"}, evq[0].cls, c);
      chk("R1", {nm, " flit"}, evq[0].flit, mk(1, 1, 8'hA5, 0, y, x));
    end
  endtask

  task automatic t_route;
    route_case("east", PL, GS, 4'd2, 4'd5, PE);
    route_case("x-first", PL, GS, 4'd5, 4'd5, PE);
    route_case("west", PN, BE, 4'd2, 4'd0, PWST);
    route_case("north", PL, GS, 4'd5, 4'd2, PN);
    route_case("south", PL, GS, 4'd0, 4'd2, PS);
    route_case("local", PE, GS, 4'd2, 4'd2, PL);
  endtask

  task automatic t_stream;
    evq.delete();
    send_pkt(PWST, BE, 4'd2, 4'd4, 8'h51, 5);
    idle(8);
    chk("R9", "stream count", evq.size(), 5);
    if (evq.size() == 5)
      for (int k = 0; k < 5; k++) begin
        chk("R8", "stream order", evq[k].flit, mk(k == 0, k == 4, 8'h51, k, 4'd2, 4'd4));
        chk("R9", "stream cycle", evq[k].cyc, evq[0].cyc + k);
      end
  endtask

  task automatic t_priority;
    evq.delete();
    tx_wok[PE] = 2'b00;
    fork
      send_pkt(PN, BE, 4'd2, 4'd3, 8'h61, 2);
      send_pkt(PS, GS, 4'd2, 4'd3, 8'h62, 2);
    join
    idle(3);
    chk("R4", "no flit while blocked", evq.size(), 0);
    tx_wok[PE] = 2'b11;
    idle(10);
    chk("R6", "both-class count", evq.size(), 4);
    if (evq.size() == 4) begin
      chk("R6", "first class", {evq[0].cls, evq[1].cls}, 2'b00);
      chk("R6", "then best effort", {evq[2].cls, evq[3].cls}, 2'b11);
    end
    evq.delete();
    tx_wok[PE] = 2'b00;
    fork
      send_pkt(PN, BE, 4'd2, 4'd3, 8'h63, 3);
      begin idle(3); send_pkt(PS, GS, 4'd2, 4'd3, 8'h64, 2); end
    join
    idle(2);
    tx_wok[PE] = 2'b11;
    idle(12);
    chk("R6", "no cut-in count", evq.size(), 5);
    if (evq.size() == 5)
      chk("R6", "no cut-in tags", {evq[0].flit[31:24], evq[2].flit[31:24], evq[3].flit[31:24]},
          {8'h63, 8'h63, 8'h64});
  endtask

  task automatic rr_round(int two_src, int one_src, logic [7:0] ta, logic [7:0] tb, logic [7:0] tc);
    evq.delete();
    fork
      begin
        send_pkt(two_src, GS, 4'd2, 4'd3, ta, 2);
        send_pkt(two_src, GS, 4'd2, 4'd3, tb, 2);
      end
      send_pkt(one_src, GS, 4'd2, 4'd3, tc, 2);
    join
    idle(12);
    chk("R5", "round count", evq.size(), 6);
    if (evq.size() == 6) begin
      for (int k = 0; k < 3; k++) begin
        chk("R5", "packet start", evq[2*k].flit[33], 1);
        chk("R5", "packet end", evq[2*k+1].flit[32], 1);
        chk("R5", "packet unbroken", evq[2*k+1].flit[31:24], evq[2*k].flit[31:24]);
      end
      chk("R7", "lone source served last", evq[4].flit[31:24] == tc, 0);
    end
  endtask

  task automatic t_full;
    evq.delete();
    tx_wok[PE] = 2'b00;
    send_pkt(PWST, GS, 4'd2, 4'd3, 8'h71, 7);
    idle(2);
    chk("R3", "write-ok low when full", rx_wok[PWST][GS], 0);
    chk("R3", "other class unaffected", rx_wok[PWST][BE], 1);
    chk("R4", "nothing sent while blocked", evq.size(), 0);
    rx_flit[PWST] = mk(1, 1, 8'hEE, 0, 4'd2, 4'd3);
    rx_wr[PWST][GS] = 1'b1;
    @(negedge clk);
    rx_wr[PWST][GS] = 1'b0;
    tx_wok[PE] = 2'b11;
    idle(15);
    chk("R3", "write while full discarded", evq.size(), 7);
    if (evq.size() == 7)
      chk("R8", "last stored flit", evq[6].flit, mk(0, 1, 8'h71, 6, 4'd2, 4'd3));
    chk("R3", "write-ok back", rx_wok[PWST][GS], 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rx_flit = '0;
    rx_wr   = '0;
    tx_wok  = '1;
    idle(3);
    t_reset;
    rst_n = 1'b1;
    idle(1);
    t_reset;
    t_route;
    t_stream;
    t_priority;
    rr_round(PN, PS, 8'h31, 8'h32, 8'h41);
    rr_round(PS, PN, 8'h51, 8'h52, 8'h61);
    t_full;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule